// File: doc/BRIEF.md
# DRAM Bank Timing Tracker

This block follows every bank of a multi-rank DRAM channel and says, each cycle, which commands the controller may legally send. The command scheduler in front of it issues activate, read, write and precharge commands with a rank, bank and row. The tracker records which row each bank has open. It also loads small per-bank down-counters, so that every legality flag comes from a compare against zero in the same cycle.

All timing values are parameters in clock cycles. The minimum row-active time is three precharge times and the activate-to-activate time on one bank is four precharge times, so neither is a separate parameter. An activate limit per rank is tracked over a sliding window, and setting the window to zero turns that limit off. A refresh timer raises a pending flag that stops new activates. A refresh is accepted once all banks are closed, and it then blocks the whole channel for the refresh cycle time. A command sent while its flag is low is dropped.

Top module: `dram_bank_timer`

## Requirements
- R1: After reset every bank is closed, `ref_pending` and `rd_valid` are low, and `act_ok` is high for every bank.
- R2: An accepted activate (`cmd_op`=0) opens the bank: in the next cycle its `row_open` bit is 1 and its field of `open_row` (bank index = rank*BANKS+bank, ROW_W bits each) holds the row.
- R3: A read (`cmd_op`=1) or write (`cmd_op`=2) to a bank is legal only from T_RCD cycles after that bank's activate.
- R4: A read accepted in cycle c drives `rd_valid` high in cycles c+T_CL through c+T_CL+T_BURST-1.
- R5: After any accepted read or write, no access to any bank is legal for T_BURST cycles.
- R6: A precharge (`cmd_op`=3) is legal from 3*T_RP cycles after the bank's activate, and it closes the bank in the next cycle.
- R7: An activate to a bank is legal only from T_RP cycles after its precharge and 4*T_RP cycles after its previous activate.
- R8: Within any T_XAW cycles at most ACT_LIMIT activates are accepted per rank; other ranks are unaffected; with T_XAW=0 there is no cap.
- R9: `ref_pending` rises exactly T_REFI cycles after an accepted refresh, and while it is high no activate is legal.
- R10: A refresh request is accepted only while `ref_pending` is high, all banks are closed and their precharge time has elapsed. Once accepted, no command is legal for T_RFC cycles.
- R11: A command or refresh request given while it is not legal is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | A command is offered this cycle |
| cmd_op | input | 2 | 0 activate, 1 read, 2 write, 3 precharge |
| cmd_rank | input | RKW | Target rank |
| cmd_bank | input | BKW | Target bank within the rank |
| cmd_row | input | ROW_W | Row for an activate |
| ref_req | input | 1 | Refresh request for the whole channel |
| row_open | output | NB | One bit per bank, set while a row is open |
| open_row | output | NB*ROW_W | Open row of each bank |
| act_ok | output | NB | Activate legal per bank |
| rw_ok | output | NB | Read/write legal per bank |
| pre_ok | output | NB | Precharge legal per bank |
| ref_ok | output | 1 | Refresh request would be accepted |
| ref_pending | output | 1 | Refresh is due |
| rd_valid | output | 1 | Read burst on the data bus |

## Verification
The hardest state to reach is a due refresh that meets open banks. The refresh timer can only be advanced by waiting, so the stimulus leaves two banks of one rank open and idles until the pending flag rises. It then offers a refresh that must be dropped, and closes the banks one cycle apart. This shows the refresh flag waiting for the later bank's precharge time. A second instance with a zero window receives the same commands, so the two ranks' activate caps can be compared cycle by cycle.

// File: rtl/dram_bank_timer.sv
module dram_bank_timer #(
  parameter int RANKS     = 2,
  parameter int BANKS     = 8,
  parameter int ROW_W     = 15,
  parameter int T_RCD     = 11,
  parameter int T_CL      = 11,
  parameter int T_RP      = 11,
  parameter int T_BURST   = 4,
  parameter int T_RFC     = 240,
  parameter int T_REFI    = 6240,
  parameter int T_XAW     = 32,
  parameter int ACT_LIMIT = 4,
  localparam int RKW = (RANKS > 1) ? $clog2(RANKS) : 1,
  localparam int BKW = (BANKS > 1) ? $clog2(BANKS) : 1,
  localparam int NB  = RANKS * BANKS
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cmd_valid,
  input  logic [1:0]            cmd_op,
  input  logic [RKW-1:0]        cmd_rank,
  input  logic [BKW-1:0]        cmd_bank,
  input  logic [ROW_W-1:0]      cmd_row,
  input  logic                  ref_req,
  output logic [NB-1:0]         row_open,
  output logic [NB*ROW_W-1:0]   open_row,
  output logic [NB-1:0]         act_ok,
  output logic [NB-1:0]         rw_ok,
  output logic [NB-1:0]         pre_ok,
  output logic                  ref_ok,
  output logic                  ref_pending,
  output logic                  rd_valid
);
  localparam int T_RAS = 3 * T_RP;
  localparam int T_RC  = 4 * T_RP;
  localparam int CW    = $clog2(T_RC + T_RCD + T_XAW + T_BURST + 2);
  localparam int RW    = $clog2(T_REFI + T_RFC + 2);

  function automatic logic [CW-1:0] dec(input logic [CW-1:0] v);
    return (v == '0) ? v : v - 1'b1;
  endfunction

  logic is_act, is_rd, is_wr, is_pre;
  assign is_act = cmd_op == 2'd0;
  assign is_rd  = cmd_op == 2'd1;
  assign is_wr  = cmd_op == 2'd2;
  assign is_pre = cmd_op == 2'd3;

  logic [NB-1:0] hit, act_go, rw_go, pre_go, rp_zero;
  logic [RANKS-1:0] win_ok, rank_act;
  logic [CW-1:0] bus_q, burst_q;
  logic [RW-1:0] refi_q, rfc_q;
  logic [T_CL-1:0] rd_pipe;
  logic busy, ref_go, rd_go;

  assign act_go = hit & {NB{is_act}} & act_ok;
  assign rw_go  = hit & {NB{is_rd | is_wr}} & rw_ok;
  assign pre_go = hit & {NB{is_pre}} & pre_ok;
  assign rd_go  = |rw_go && is_rd;

  assign busy        = rfc_q != '0;
  assign ref_pending = refi_q == '0;
  assign ref_ok      = ref_pending && !busy && (row_open == '0) && (&rp_zero);
  assign ref_go      = ref_req && ref_ok;

  for (genvar i = 0; i < NB; i++) begin : g_bank
    localparam int RK = i / BANKS;
    localparam int BK = i % BANKS;
    logic [CW-1:0] rcd_q, ras_q, rc_q, rp_q;
    logic [ROW_W-1:0] row_q;
    logic open_q;

    assign hit[i] = cmd_valid && (cmd_rank == RKW'(RK)) && (cmd_bank == BKW'(BK));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        rcd_q  <= '0;
        ras_q  <= '0;
        rc_q   <= '0;
        rp_q   <= '0;
        open_q <= 1'b0;
        row_q  <= '0;
      end else begin
        rcd_q <= act_go[i] ? CW'(T_RCD - 1) : dec(rcd_q);
        ras_q <= act_go[i] ? CW'(T_RAS - 1) : dec(ras_q);
        rc_q  <= act_go[i] ? CW'(T_RC - 1)  : dec(rc_q);
        rp_q  <= pre_go[i] ? CW'(T_RP - 1)  : dec(rp_q);
        if (act_go[i]) begin
          open_q <= 1'b1;
          row_q  <= cmd_row;
        end else if (pre_go[i]) begin
          open_q <= 1'b0;
        end
      end
    end

    assign row_open[i]                  = open_q;
    assign open_row[i*ROW_W +: ROW_W]   = row_q;
    assign rp_zero[i]                   = rp_q == '0;
    assign act_ok[i] = !open_q && rp_zero[i] && (rc_q == '0) && win_ok[RK] && !ref_pending && !busy;
    assign rw_ok[i]  = open_q && (rcd_q == '0) && (bus_q == '0) && !busy;
    assign pre_ok[i] = open_q && (ras_q == '0) && !busy;

    // R2
    open_after_act_chk: assert property (@(posedge clk) disable iff (!rst_n)
      act_go[i] |=> row_open[i]);
    // R3
    rcd_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (T_RCD > 1 && act_go[i]) |=> !rw_ok[i]);
    // R6
    ras_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      act_go[i] |=> !pre_ok[i]);
  end

  for (genvar r = 0; r < RANKS; r++) begin : g_rank
    assign rank_act[r] = |act_go[r*BANKS +: BANKS];
    if (T_XAW == 0) begin : g_nowin
      assign win_ok[r] = 1'b1;
    end else begin : g_win
      logic [CW-1:0] slot_q [ACT_LIMIT];
      logic [ACT_LIMIT-1:0] free, take;
      for (genvar s = 0; s < ACT_LIMIT; s++) begin : g_slot
        assign free[s] = slot_q[s] == '0;
      end
      assign take      = free & (~free + 1'b1);
      assign win_ok[r] = |free;
      always_ff @(posedge clk) begin
        for (int s = 0; s < ACT_LIMIT; s++) begin
          if (!rst_n)
            slot_q[s] <= '0;
          else
            slot_q[s] <= (rank_act[r] && take[s]) ? CW'(T_XAW - 1) : dec(slot_q[s]);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_q   <= '0;
      burst_q <= '0;
      rd_pipe <= '0;
      refi_q  <= RW'(T_REFI - 1);
      rfc_q   <= '0;
    end else begin
      bus_q   <= (|rw_go) ? CW'(T_BURST - 1) : dec(bus_q);
      burst_q <= rd_pipe[T_CL-1] ? CW'(T_BURST - 1) : dec(burst_q);
      rd_pipe <= T_CL'({rd_pipe, rd_go});
      if (ref_go)
        refi_q <= RW'(T_REFI - 1);
      else if (refi_q != '0)
        refi_q <= refi_q - 1'b1;
      if (ref_go)
        rfc_q <= RW'(T_RFC - 1);
      else if (rfc_q != '0)
        rfc_q <= rfc_q - 1'b1;
    end
  end

  assign rd_valid = rd_pipe[T_CL-1] || (burst_q != '0);

  // R5
  bus_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (T_BURST > 1 && (|rw_go)) |=> (rw_ok == '0));
  // R9
  refi_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (T_REFI > 1 && ref_go) |=> !ref_pending);
  // R10
  rfc_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (T_RFC > 1 && ref_go) |=> ((act_ok | rw_ok | pre_ok) == '0));
  // R10
  ref_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ref_go |-> (row_open == '0));
endmodule

// File: tb/dram_bank_timer_bench.sv
`timescale 1ns/1ps
module dram_bank_timer_bench;
  localparam int RANKS = 2, BANKS = 4, ROW_W = 8;
  localparam int T_RCD = 3, T_CL = 4, T_RP = 2, T_BURST = 4;
  localparam int T_RFC = 10, T_REFI = 300, T_XAW = 30, ACT_LIMIT = 2;
  localparam int NB = RANKS * BANKS;

  logic clk = 0, rst_n = 0, cmd_valid = 0, ref_req = 0;
  logic [1:0] cmd_op = 0;
  logic [0:0] cmd_rank = 0;
  logic [1:0] cmd_bank = 0;
  logic [ROW_W-1:0] cmd_row = 0;
  logic [NB-1:0] row_open, act_ok, rw_ok, pre_ok;
  logic [NB*ROW_W-1:0] open_row;
  logic ref_ok, ref_pending, rd_valid;
  logic [NB-1:0] nw_open, nw_act, nw_rw, nw_pre;
  logic [NB*ROW_W-1:0] nw_row;
  logic nw_refok, nw_pend, nw_rd;

  always #2 clk = ~clk;

  dram_bank_timer #(.RANKS(RANKS), .BANKS(BANKS), .ROW_W(ROW_W), .T_RCD(T_RCD), .T_CL(T_CL),
    .T_RP(T_RP), .T_BURST(T_BURST), .T_RFC(T_RFC), .T_REFI(T_REFI), .T_XAW(T_XAW),
    .ACT_LIMIT(ACT_LIMIT)) u_dram_bank_timer (
    .clk, .rst_n, .cmd_valid, .cmd_op, .cmd_rank, .cmd_bank, .cmd_row, .ref_req,
    .row_open, .open_row, .act_ok, .rw_ok, .pre_ok, .ref_ok, .ref_pending, .rd_valid);

  dram_bank_timer #(.RANKS(RANKS), .BANKS(BANKS), .ROW_W(ROW_W), .T_RCD(T_RCD), .T_CL(T_CL),
    .T_RP(T_RP), .T_BURST(T_BURST), .T_RFC(T_RFC), .T_REFI(T_REFI), .T_XAW(0),
    .ACT_LIMIT(ACT_LIMIT)) u_dram_bank_timer_nowin (
    .clk, .rst_n, .cmd_valid, .cmd_op, .cmd_rank, .cmd_bank, .cmd_row, .ref_req,
    .row_open(nw_open), .open_row(nw_row), .act_ok(nw_act), .rw_ok(nw_rw), .pre_ok(nw_pre),
    .ref_ok(nw_refok), .ref_pending(nw_pend), .rd_valid(nw_rd));

  int cyc = 0, checks = 0, failures = 0;
  int exp_q[$];
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s cyc=%0d actual=%0h expected=%0h", tag, cyc, act, exp);
    end
  endtask

  // R4 scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic e;
      while (exp_q.size() > 0 && cyc >= exp_q[0] + T_BURST) begin
        checks++;
        void'(exp_q.pop_front());
      end
      e = (exp_q.size() > 0) && (cyc >= exp_q[0]);
      if (rd_valid !== e) begin
        failures++;
        $display("FAIL R4 rd_valid cyc=%0d actual=%0b expected=%0b", cyc, rd_valid, e);
      end
    end
  end

  task automatic goto(input int x);
    @(negedge clk);
    while (cyc < x) @(negedge clk);
  endtask

  task automatic issue(input logic [1:0] op, input int rk, input int bk, input int row, input bit exp_rd);
    cmd_valid = 1; cmd_op = op; cmd_rank = rk[0:0]; cmd_bank = bk[1:0]; cmd_row = row[ROW_W-1:0];
    if (exp_rd) exp_q.push_back(cyc + T_CL);
    @(posedge clk); #1 cmd_valid = 0;
  endtask

  task automatic pulse_ref();
    ref_req = 1;
    @(posedge clk); #1 ref_req = 0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #80000;
    failures++;
    $display("FAIL watchdog expired cyc=%0d actual=running expected=done", cyc);
    finish_run();
  end

  initial begin
    int x, c;
    repeat (3) @(negedge clk);
    rst_n = 1;
    goto(5);
    chk("R1 row_open", row_open, 0);
    chk("R1 ref_pending", ref_pending, 0);
    chk("R1 rd_valid", rd_valid, 0);
    chk("R1 act_ok", act_ok, 8'hFF);

    goto(10); issue(2'd0, 0, 1, 8'h5A, 0);
    goto(11);
    chk("R2 row_open", row_open, 8'h02);
    chk("R2 open_row", open_row[1*ROW_W +: ROW_W], 8'h5A);
    goto(12); chk("R3 rw_ok early", rw_ok[1], 0);
    goto(13); chk("R3 rw_ok ready", rw_ok[1], 1);
    issue(2'd1, 0, 2, 0, 0);
    goto(14);
    chk("R11 closed read ignored", row_open, 8'h02);
    chk("R11 bus untouched", rw_ok[1], 1);
    issue(2'd1, 0, 1, 0, 1);
    goto(15);
    chk("R5 bus busy", rw_ok, 0);
    chk("R6 pre early", pre_ok[1], 0);
    goto(16); chk("R6 pre ready", pre_ok[1], 1);
    goto(17);
    chk("R5 bus still busy", rw_ok[1], 0);
    chk("R4 before data", rd_valid, 0);
    goto(18);
    chk("R5 bus free", rw_ok[1], 1);
    chk("R4 data start", rd_valid, 1);
    issue(2'd2, 0, 1, 0, 0);
    goto(21); chk("R4 data last", rd_valid, 1);
    goto(22);
    chk("R4 data end", rd_valid, 0);
    issue(2'd3, 0, 1, 0, 0);
    goto(23);
    chk("R6 closed", row_open[1], 0);
    chk("R7 rp wait", act_ok[1], 0);
    goto(24); chk("R7 rp done", act_ok[1], 1);

    goto(30); issue(2'd0, 1, 0, 8'h11, 0);
    goto(31); issue(2'd0, 1, 1, 8'h22, 0);
    goto(32);
    chk("R8 rank1 capped", act_ok[6], 0);
    chk("R8 rank0 free", act_ok[2], 1);
    chk("R8 zero window", nw_act[6], 1);
    goto(59); chk("R8 window held", act_ok[6], 0);
    goto(60); chk("R8 window slides", act_ok[6], 1);

    x = 0;
    while (!ref_pending && x < 1000) begin goto(cyc + 1); x++; end
    chk("R9 pending seen", ref_pending, 1);
    chk("R9 act blocked", act_ok, 0);
    chk("R10 open banks", ref_ok, 0);
    pulse_ref();
    goto(cyc);
    chk("R11 ref ignored", ref_pending, 1);
    x = cyc;
    issue(2'd3, 1, 0, 0, 0);
    goto(x + 1); issue(2'd3, 1, 1, 0, 0);
    goto(x + 2); chk("R10 rp wait", ref_ok, 0);
    goto(x + 3); chk("R10 ready", ref_ok, 1);
    c = cyc;
    pulse_ref();
    goto(c + 1);
    chk("R9 cleared", ref_pending, 0);
    chk("R10 all blocked", act_ok | rw_ok | pre_ok, 0);
    goto(c + T_RFC - 1); chk("R10 still blocked", act_ok, 0);
    goto(c + T_RFC); chk("R10 released", act_ok, 8'hFF);
    goto(c + T_REFI - 1); chk("R9 not yet", ref_pending, 0);
    goto(c + T_REFI); chk("R9 due", ref_pending, 1);
    goto(c + T_REFI + 2);
    finish_run();
  end
endmodule